// File: doc/BRIEF.md
# Timer Interrupt Status Flags with Match Clear-Lock

This block keeps the five interrupt flags of one general-purpose timer. Single-cycle event strobes come in from the overflow detector, the two compare-match detectors and the two capture channels, and each strobe latches its own flag. Software reads the flags through a 32-bit status word. It removes flags by writing ones to the write port, so every write is a write-one-to-clear. A registered interrupt request is raised when any flag is set and its per-source enable bit is also set.

One rule changes the usual write-one-to-clear behaviour. Suppose the timer is stopped and one of its compare values equals the live counter. That compare flag is then re-asserted on every cycle, so a clear write cannot remove it. The lock ends when the counter or that compare value changes, or when the timer starts running again. After that the next clear write works as usual.

Top module: `tmr_irq_status`

## Requirements
- R1: When reset is asserted, all five flags and the interrupt request go to 0.
- R2: An event strobe sets its flag on the next clock edge, whether or not that source is enabled. The bit positions are: overflow at bit 0, compare 0 at bit 1, compare 1 at bit 2, capture A at bit 3 and capture B at bit 4.
- R3: On a clock edge with the write strobe high, each flag whose bit in the write data is 1 is cleared.
- R4: A 0 in the write data, or any data with the write strobe low, leaves the flags unchanged.
- R5: Writing 1 to a flag that reads 0 leaves both the status word and the interrupt request unchanged. No flag is set unless its event strobe or its lock condition is present.
- R6: If an event strobe and a clear write hit the same flag in the same cycle, the flag is 1 afterwards.
- R7: While the timer is stopped and compare value N equals the counter, compare flag N is set every cycle and clear writes to it have no effect. While the timer runs, an equal value does not set the flag.
- R8: The lock is released as soon as the counter changes, compare value N changes, or the timer runs. A clear write in that cycle then removes the flag.
- R9: Status word bits 31 down to 5 always read 0.
- R10: The interrupt request is a register. After each edge it holds the OR, over the five sources, of each flag ANDed with its enable bit, with both values taken just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_ovf | input | 1 | Overflow event strobe |
| evt_cmp0 | input | 1 | Compare 0 match strobe |
| evt_cmp1 | input | 1 | Compare 1 match strobe |
| evt_capa | input | 1 | Capture A event strobe |
| evt_capb | input | 1 | Capture B event strobe |
| cnt_val | input | CNT_W | Live timer counter value |
| cmp0_val | input | CNT_W | Compare 0 value |
| cmp1_val | input | CNT_W | Compare 1 value |
| run | input | 1 | Timer running (1) or stopped (0) |
| irq_en | input | 5 | Per-source interrupt enables, same bit positions as the flags |
| wr_valid | input | 1 | Write strobe for the clear port |
| wr_data | input | 5 | Clear mask, 1 clears that flag |
| stat_word | output | 32 | Status word readback, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
A table-driven sequence sets flags in several groups and clears them with these masks: all zeros, write strobe low, a partial mask, a repeated mask aimed at flags that are already clear, and a clear that lands in the same cycle as a strobe. Comparing these results separates the set-wins rule from a plain clear, and a strobe-qualified write from an unqualified one. A second pass changes the enable masks with the flags held constant, so the one-cycle lag of the request can be told apart from a combinational path. Directed tests then stop the timer on a match for each compare channel. They release the lock in three ways: by moving the counter, by moving the compare value, and by restarting the timer. They also check that a running timer on the same values sets nothing.

// File: rtl/tmr_irq_pkg.sv
// Package: shared constants and types for the timer interrupt status block.
// Assumes five interrupt sources in a fixed bit order that software decodes.
package tmr_irq_pkg;
    localparam int SRC_N    = 5;
    localparam int IDX_OVF  = 0;
    localparam int IDX_CMP0 = 1;
    localparam int IDX_CMP1 = 2;
    localparam int IDX_CAPA = 3;
    localparam int IDX_CAPB = 4;
    localparam int CMP_N    = 2;
    localparam int STAT_W   = 32;

    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/tmr_match_lock.sv
// Module: detects the clear-lock condition of one compare channel.
// It assumes the counter and compare value are stable register outputs,
// so the equality result is safe to use within one cycle.
module tmr_match_lock #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             run_i,
    output logic             lock_o
);
    // Lock is active only while the timer is stopped on an exact match.
    always_comb begin
        lock_o = (!run_i) && (cnt_i == cmp_i);
    end
endmodule

// File: rtl/tmr_flag_cell.sv
// Module: one sticky interrupt flag. A set request takes priority over a clear.
// It assumes the set and clear requests are already qualified by the caller.
module tmr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Flag storage: reset to 0, set wins over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/tmr_irq_combine.sv
// Module: combines the flags with the enables into one registered request.
// It assumes the flags and enables are synchronous to clk.
module tmr_irq_combine #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic req_d;

    // Request term: any flag that is set and enabled.
    always_comb begin
        req_d = |(flags_i & en_i);
    end

    // Request register: one cycle behind the flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= req_d;
    end
endmodule

// File: rtl/tmr_irq_status.sv
// Module: interrupt status flags of a general-purpose timer, with a
// write-one-to-clear port and a clear-lock while the timer is stopped on a
// compare match. It assumes event strobes are one cycle wide and that the bus
// decoder raises wr_valid only for writes aimed at this status word.
module tmr_irq_status
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_ovf,
    input  logic             evt_cmp0,
    input  logic             evt_cmp1,
    input  logic             evt_capa,
    input  logic             evt_capb,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp0_val,
    input  logic [CNT_W-1:0] cmp1_val,
    input  logic             run,
    input  logic [4:0]       irq_en,
    input  logic             wr_valid,
    input  logic [4:0]       wr_data,
    output logic [31:0]      stat_word,
    output logic             irq
);
    localparam int PAD_W = STAT_W - SRC_N;

    src_vec_t         evt_vec;
    src_vec_t         set_vec;
    src_vec_t         clr_vec;
    src_vec_t         flag_vec;
    logic [CMP_N-1:0] lock_vec;
    logic [CNT_W-1:0] cmp_arr [CMP_N];

    // Event gather: place each strobe at its software-visible bit position.
    always_comb begin
        evt_vec           = '0;
        evt_vec[IDX_OVF]  = evt_ovf;
        evt_vec[IDX_CMP0] = evt_cmp0;
        evt_vec[IDX_CMP1] = evt_cmp1;
        evt_vec[IDX_CAPA] = evt_capa;
        evt_vec[IDX_CAPB] = evt_capb;
    end

    // Compare value gather: index the compare channels for the lock loop.
    always_comb begin
        cmp_arr[0] = cmp0_val;
        cmp_arr[1] = cmp1_val;
    end

    // One lock detector per compare channel.
    for (genvar k = 0; k < CMP_N; k++) begin : g_lock
        tmr_match_lock #(.CNT_W(CNT_W)) u_lock (
            .cnt_i  (cnt_val),
            .cmp_i  (cmp_arr[k]),
            .run_i  (run),
            .lock_o (lock_vec[k])
        );
    end

    // Set sources: strobes, plus the lock re-asserting its compare flag.
    always_comb begin
        set_vec = evt_vec;
        for (int k = 0; k < CMP_N; k++) begin
            set_vec[IDX_CMP0 + k] = evt_vec[IDX_CMP0 + k] | lock_vec[k];
        end
    end

    // Clear requests: the write mask, only on a valid write.
    always_comb begin
        clr_vec = wr_valid ? src_vec_t'(wr_data) : '0;
    end

    // One sticky flag per interrupt source.
    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        tmr_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flag_vec[i])
        );
    end

    // Readback: flags in the low bits, reserved bits tied to zero.
    always_comb begin
        stat_word = {{PAD_W{1'b0}}, flag_vec};
    end

    tmr_irq_combine #(.N(SRC_N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flag_vec),
        .en_i    (src_vec_t'(irq_en)),
        .irq_o   (irq)
    );
endmodule

// File: rtl/tmr_irq_status_chk.sv
// Module: property checker for tmr_irq_status, attached by bind. It observes
// ports only and works out the lock condition on its own from the port values.
module tmr_irq_status_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_ovf,
    input logic             evt_cmp0,
    input logic             evt_cmp1,
    input logic             evt_capa,
    input logic             evt_capb,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] cmp0_val,
    input logic [CNT_W-1:0] cmp1_val,
    input logic             run,
    input logic [4:0]       irq_en,
    input logic             wr_valid,
    input logic [4:0]       wr_data,
    input logic [31:0]      stat_word,
    input logic             irq
);
    logic [4:0] ev;
    logic [4:0] setx;
    logic [4:0] wmask;
    logic       lk0;
    logic       lk1;

    // Reference set sources and write mask, derived from the ports.
    always_comb begin
        ev    = {evt_capb, evt_capa, evt_cmp1, evt_cmp0, evt_ovf};
        lk0   = !run && (cmp0_val == cnt_val);
        lk1   = !run && (cmp1_val == cnt_val);
        setx  = ev | {2'b00, lk1, lk0, 1'b0};
        wmask = wr_valid ? wr_data : 5'b0;
    end

    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (stat_word == 32'd0 && !irq));

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((stat_word[4:0] & $past(ev)) == $past(ev)));

    p_clear_works_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> ((stat_word[4:0] & $past(wr_data & ~setx)) == 5'b0));

    p_hold_unwritten_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_word[4:0] & ~wmask) & ~stat_word[4:0]) == 5'b0));

    p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_word[4:0] & ~$past(stat_word[4:0]) & ~$past(setx)) == 5'b0));

    p_lock_cmp0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk0 |=> stat_word[1]);

    p_lock_cmp1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk1 |=> stat_word[2]);

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[31:5] == 27'd0);

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat_word[4:0] & irq_en))));
endmodule

bind tmr_irq_status tmr_irq_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_ovf   (evt_ovf),
    .evt_cmp0  (evt_cmp0),
    .evt_cmp1  (evt_cmp1),
    .evt_capa  (evt_capa),
    .evt_capb  (evt_capb),
    .cnt_val   (cnt_val),
    .cmp0_val  (cmp0_val),
    .cmp1_val  (cmp1_val),
    .run       (run),
    .irq_en    (irq_en),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .stat_word (stat_word),
    .irq       (irq)
);

// File: tb/tmr_irq_status_test.sv
// Bench: table-driven flag set/clear sequence, then directed lock and reset tests.
module tmr_irq_status_test;
    localparam int CNT_W = 16;
    localparam int NVEC  = 13;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             evt_ovf, evt_cmp0, evt_cmp1, evt_capa, evt_capb;
    logic [CNT_W-1:0] cnt_val, cmp0_val, cmp1_val;
    logic             run;
    logic [4:0]       irq_en;
    logic             wr_valid;
    logic [4:0]       wr_data;
    logic [31:0]      stat_word;
    logic             irq;

    int n_chk  = 0;
    int n_fail = 0;

    // Vector layout: {events[4:0], wr_valid, wr_data[4:0], irq_en[4:0], expected flags[4:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {5'b00001, 1'b0, 5'b00000, 5'b11111, 5'b00001}, // R2 overflow
        {5'b00110, 1'b0, 5'b00000, 5'b11111, 5'b00111}, // R2 both compares
        {5'b11000, 1'b0, 5'b00000, 5'b11111, 5'b11111}, // R2 both captures
        {5'b00000, 1'b1, 5'b00000, 5'b11111, 5'b11111}, // R4 zero mask
        {5'b00000, 1'b0, 5'b11111, 5'b11111, 5'b11111}, // R4 strobe low
        {5'b00000, 1'b1, 5'b00101, 5'b11111, 5'b11010}, // R3 partial clear
        {5'b00000, 1'b1, 5'b00101, 5'b11111, 5'b11010}, // R5 clear of zero flags
        {5'b00010, 1'b1, 5'b00010, 5'b11111, 5'b11010}, // R6 set wins
        {5'b00000, 1'b1, 5'b11111, 5'b11111, 5'b00000}, // R3 clear all
        {5'b10000, 1'b0, 5'b00000, 5'b00000, 5'b10000}, // R2 raw while disabled
        {5'b00000, 1'b0, 5'b00000, 5'b10000, 5'b10000}, // R10 enable later
        {5'b00000, 1'b1, 5'b10000, 5'b10000, 5'b00000}, // R10 request from old flag
        {5'b00000, 1'b0, 5'b00000, 5'b11111, 5'b00000}  // R10 request drops
    };

    tmr_irq_status #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .evt_ovf(evt_ovf), .evt_cmp0(evt_cmp0), .evt_cmp1(evt_cmp1),
        .evt_capa(evt_capa), .evt_capb(evt_capb),
        .cnt_val(cnt_val), .cmp0_val(cmp0_val), .cmp1_val(cmp1_val),
        .run(run), .irq_en(irq_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .stat_word(stat_word), .irq(irq)
    );

    always #2 clk = ~clk; // 250 MHz

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic [4:0] ev, input logic wv, input logic [4:0] wd, input logic [4:0] en);
        {evt_capb, evt_capa, evt_cmp1, evt_cmp0, evt_ovf} = ev;
        wr_valid = wv;
        wr_data  = wd;
        irq_en   = en;
        @(posedge clk);
        @(negedge clk);
        {evt_capb, evt_capa, evt_cmp1, evt_cmp0, evt_ovf} = 5'b0;
        wr_valid = 1'b0;
        wr_data  = 5'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] prev_flags;
        logic       exp_irq;
        rst_n = 1'b0;
        {evt_capb, evt_capa, evt_cmp1, evt_cmp0, evt_ovf} = 5'b0;
        cnt_val = 16'd5; cmp0_val = 16'd100; cmp1_val = 16'd200;
        run = 1'b1; irq_en = 5'b11111; wr_valid = 1'b0; wr_data = 5'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 flags after reset", stat_word, 32'd0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;

        // Table walk
        prev_flags = 5'b0;
        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][20:16], VEC[v][15], VEC[v][14:10], VEC[v][9:5]);
            exp_irq = |(prev_flags & VEC[v][9:5]);
            check($sformatf("R2/R3/R4/R5/R6 vector %0d flags", v), stat_word, {27'd0, VEC[v][4:0]});
            check($sformatf("R10 vector %0d irq", v), {31'd0, irq}, {31'd0, exp_irq});
            prev_flags = VEC[v][4:0];
        end

        // R9: upper bits stay zero with flags set and a full write
        step(5'b11111, 1'b0, 5'b0, 5'b0);
        check("R9 upper bits zero", {5'd0, stat_word[31:5]}, 32'd0);
        step(5'b0, 1'b1, 5'b11111, 5'b0);
        check("R3 clear before lock tests", stat_word, 32'd0);

        // R7: running on equal value sets nothing
        cnt_val = 16'd100;
        step(5'b0, 1'b0, 5'b0, 5'b0);
        check("R7 running equal no set", stat_word, 32'd0);

        // R7: stopped on cmp0 match sets and locks the flag
        run = 1'b0;
        step(5'b0, 1'b0, 5'b0, 5'b0);
        check("R7 stopped match sets cmp0 flag", stat_word, 32'h2);
        step(5'b0, 1'b1, 5'b00010, 5'b0);
        check("R7 clear ignored under lock", stat_word, 32'h2);
        step(5'b0, 1'b1, 5'b00010, 5'b0);
        check("R7 second clear ignored", stat_word, 32'h2);

        // R8: counter moves, clear works
        cnt_val = 16'd101;
        step(5'b0, 1'b1, 5'b00010, 5'b0);
        check("R8 counter change releases cmp0", stat_word, 32'd0);

        // R7/R8: cmp1 lock released by restarting the timer
        cnt_val = 16'd200;
        step(5'b0, 1'b0, 5'b0, 5'b00100);
        check("R7 stopped match sets cmp1 flag", stat_word, 32'h4);
        step(5'b0, 1'b1, 5'b00100, 5'b00100);
        check("R7 cmp1 clear ignored", stat_word, 32'h4);
        check("R10 irq from locked flag", {31'd0, irq}, 32'd1);
        run = 1'b1;
        step(5'b0, 1'b1, 5'b00100, 5'b00100);
        check("R8 run releases cmp1", stat_word, 32'd0);

        // R8: compare value moves, clear works
        run = 1'b0; cnt_val = 16'd150; cmp1_val = 16'd150;
        step(5'b0, 1'b0, 5'b0, 5'b0);
        check("R7 cmp1 locked again", stat_word, 32'h4);
        cmp1_val = 16'd151;
        step(5'b0, 1'b1, 5'b00100, 5'b0);
        check("R8 compare change releases cmp1", stat_word, 32'd0);

        // R1: reset in mid-run clears flags and request
        run = 1'b1;
        step(5'b11111, 1'b0, 5'b0, 5'b11111);
        step(5'b0, 1'b0, 5'b0, 5'b11111);
        check("R1 precondition irq high", {31'd0, irq}, 32'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 flags cleared by reset", stat_word, 32'd0);
        check("R1 irq cleared by reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule